// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This block is a small register-mapped peripheral that drives a configuration clock pin with a burst of a programmed length. Software writes a pulse count into the count register. The block then toggles its clock output that many times. Each pulse is stretched by a compile-time divider, so the burst runs at a slower rate than the system clock.

When the last pulse has been issued, a sticky completion flag comes up in the status register. It stays set until software writes a one to it. The usual driver sequence is:

1. Clear any stale completion.
2. Write the count.
3. Poll the status word until the flag appears.
4. Clear the flag again.

While a burst runs, a busy output is high and a busy bit is visible in the status word. A new count written during a burst is dropped.

Top module: `cfgclk_burst`

## Requirements
- R1: The bus is 32 bits wide with word-aligned offsets. The count register sits at offset 0x08 and the status register at offset 0x0C. Read data is combinational from `bus_addr` while `bus_rd` is high, and is zero while `bus_rd` is low.
- R2: A write to offset 0x08 while idle takes the count from `bus_wdata[CNT_W-1:0]`; upper data bits are ignored. A non-zero count starts a burst: from the next cycle `burst_busy` is 1 and `burst_clk` is 1.
- R3: A burst of count N issues exactly N pulses. Each pulse is high for DIV cycles and then low for DIV cycles. `burst_busy` stays high for exactly 2*DIV*N cycles. `burst_clk` is low whenever `burst_busy` is low.
- R4: Status bit 0 (done) becomes 1 on the same edge on which `burst_busy` falls, and it stays 1 afterwards.
- R5: A write to offset 0x0C with data bit 0 equal to 1 clears done. Bit 0 equal to 0 leaves done unchanged. If a clear coincides with the end of a burst, done ends up set.
- R6: A count of zero issues no pulse, leaves `burst_busy` at 0, and sets done on the next edge.
- R7: A count write while `burst_busy` is 1 is ignored. The running burst keeps its original length, and the count readback is unchanged.
- R8: Status bit 1 reads the busy state. The count register reads back the last accepted count in bits CNT_W-1:0, with the upper bits zero.
- R9: Reads of any other offset (including misaligned ones) return zero. Writes to them change no state.
- R10: After reset, `burst_clk` and `burst_busy` are 0, done is 0 and the count readback is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, qualifies read data |
| bus_rdata | output | 32 | Read data, combinational |
| burst_clk | output | 1 | Divided configuration clock output |
| burst_busy | output | 1 | High while a burst is running |

## Verification
The count is swept over every value from 0 to 24, plus 256 and 2047, with a divider of three. Each burst is measured for cycle count, pulse count, and the width of every high and low phase. This separates off-by-one errors in the pulse counter from errors in the divider.

Zero count and a count with garbage in the upper data bits are tried separately. A count write is placed in the middle of a burst. A clear is timed to land on the very edge where a burst ends, which tells set-over-clear priority apart from its opposite.

Writes and reads at unmapped and misaligned offsets are followed by readbacks of both registers.

// File: rtl/cfgclk_burst_pkg.sv
package cfgclk_burst_pkg;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_COUNT  = 2'd1,
      SEL_STATUS = 2'd2
   } reg_sel_e;

   localparam int STAT_DONE_BIT = 0;
   localparam int STAT_BUSY_BIT = 1;
   localparam int BUS_W         = 32;

endpackage

// File: rtl/cfgclk_burst_div.sv
module cfgclk_burst_div #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int DW = $clog2(DIV);
         logic [DW-1:0] phase_cnt;
         logic          wrap;

         assign wrap = (phase_cnt == DW'(DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_cnt <= '0;
            end else if (restart || !run || wrap) begin
               phase_cnt <= '0;
            end else begin
               phase_cnt <= phase_cnt + 1'b1;
            end
         end

         assign tick = run && wrap;
      end
   endgenerate
endmodule

// File: rtl/cfgclk_burst_seq.sv
module cfgclk_burst_seq #(
   parameter int CNT_W = 12,
   parameter int DIV   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_cnt,
   output logic             busy,
   output logic             pin,
   output logic             finish
);
   logic             tick;
   logic [CNT_W-1:0] remain;

   cfgclk_burst_div #(.DIV(DIV)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (start),
      .tick    (tick)
   );

   assign finish = busy && tick && !pin && (remain == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         pin    <= 1'b0;
         remain <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         pin    <= 1'b1;
         remain <= start_cnt;
      end else if (busy && tick) begin
         if (pin) begin
            pin <= 1'b0;
         end else if (remain == CNT_W'(1)) begin
            busy   <= 1'b0;
            remain <= '0;
         end else begin
            remain <= remain - 1'b1;
            pin    <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfgclk_burst_regs.sv
module cfgclk_burst_regs
   import cfgclk_burst_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          CNT_W    = 12,
   parameter logic [31:0] CNT_OFS  = 32'h08,
   parameter logic [31:0] STAT_OFS = 32'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_rd,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              busy,
   input  logic              finish,
   output logic              start,
   output logic [CNT_W-1:0]  prog_cnt,
   output logic              done_flag
);
   reg_sel_e         sel;
   logic             cnt_take;
   logic             zero_hit;
   logic             clr_req;
   logic [CNT_W-1:0] new_cnt;

   always_comb begin
      if (bus_addr == CNT_OFS[ADDR_W-1:0])       sel = SEL_COUNT;
      else if (bus_addr == STAT_OFS[ADDR_W-1:0]) sel = SEL_STATUS;
      else                                       sel = SEL_NONE;
   end

   assign new_cnt  = bus_wdata[CNT_W-1:0];
   assign cnt_take = bus_wr && (sel == SEL_COUNT) && !busy;
   assign start    = cnt_take && (new_cnt != '0);
   assign zero_hit = cnt_take && (new_cnt == '0);
   assign clr_req  = bus_wr && (sel == SEL_STATUS) && bus_wdata[STAT_DONE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_cnt  <= '0;
         done_flag <= 1'b0;
      end else begin
         if (cnt_take) prog_cnt <= new_cnt;
         if (finish || zero_hit) done_flag <= 1'b1;
         else if (clr_req)       done_flag <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            SEL_COUNT:  bus_rdata[CNT_W-1:0] = prog_cnt;
            SEL_STATUS: begin
               bus_rdata[STAT_DONE_BIT] = done_flag;
               bus_rdata[STAT_BUSY_BIT] = busy;
            end
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/cfgclk_burst.sv
module cfgclk_burst
   import cfgclk_burst_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          CNT_W    = 12,
   parameter int          DIV      = 2,
   parameter logic [31:0] CNT_OFS  = 32'h08,
   parameter logic [31:0] STAT_OFS = 32'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              burst_clk,
   output logic              burst_busy
);
   generate
      if (CNT_W < 11 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("cfgclk_burst: CNT_W must lie in 11..32");
      end
      if (DIV < 1) begin : g_bad_div
         $error("cfgclk_burst: DIV must be at least 1");
      end
      if (CNT_OFS[1:0] != 2'b00 || STAT_OFS[1:0] != 2'b00 || CNT_OFS == STAT_OFS) begin : g_bad_ofs
         $error("cfgclk_burst: offsets must be distinct and word aligned");
      end
      if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
         $error("cfgclk_burst: ADDR_W out of range");
      end
   endgenerate

   logic             start;
   logic             finish;
   logic [CNT_W-1:0] prog_cnt;
   logic             done_flag;

   cfgclk_burst_regs #(
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .CNT_OFS  (CNT_OFS),
      .STAT_OFS (STAT_OFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .busy      (burst_busy),
      .finish    (finish),
      .start     (start),
      .prog_cnt  (prog_cnt),
      .done_flag (done_flag)
   );

   cfgclk_burst_seq #(
      .CNT_W (CNT_W),
      .DIV   (DIV)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_cnt (prog_cnt_next(bus_wdata)),
      .busy      (burst_busy),
      .pin       (burst_clk),
      .finish    (finish)
   );

   function automatic logic [CNT_W-1:0] prog_cnt_next(input logic [31:0] d);
      return d[CNT_W-1:0];
   endfunction
endmodule

// File: rtl/cfgclk_burst_chk.sv
module cfgclk_burst_chk #(
   parameter int          ADDR_W   = 8,
   parameter int          CNT_W    = 12,
   parameter int          DIV      = 2,
   parameter logic [31:0] CNT_OFS  = 32'h08,
   parameter logic [31:0] STAT_OFS = 32'h0C
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic              burst_clk,
   input logic              burst_busy,
   input logic              done_flag,
   input logic [CNT_W-1:0]  prog_cnt
);
   logic [31:0] hi_run;
   logic        cnt_wr;
   logic        unmapped;

   assign cnt_wr   = bus_wr && (bus_addr == CNT_OFS[ADDR_W-1:0]);
   assign unmapped = (bus_addr != CNT_OFS[ADDR_W-1:0]) && (bus_addr != STAT_OFS[ADDR_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_run <= '0;
      else if (burst_clk) hi_run <= hi_run + 1;
      else                hi_run <= '0;
   end

   AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_busy |-> !burst_clk); // R3
   AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(burst_clk) |-> (hi_run == 32'(DIV))); // R3
   AST_START_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !burst_busy && bus_wdata[CNT_W-1:0] != '0) |=> (burst_busy && burst_clk)); // R2
   AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(burst_busy) |-> done_flag); // R4
   AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STAT_OFS[ADDR_W-1:0] && bus_wdata[0] && !burst_busy) |=> !done_flag); // R5
   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !burst_busy && bus_wdata[CNT_W-1:0] == '0) |=> (done_flag && !burst_busy)); // R6
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && burst_busy) |=> $stable(prog_cnt)); // R7
   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |-> (bus_rdata == 32'h0)); // R9
endmodule

bind cfgclk_burst cfgclk_burst_chk #(
   .ADDR_W   (ADDR_W),
   .CNT_W    (CNT_W),
   .DIV      (DIV),
   .CNT_OFS  (CNT_OFS),
   .STAT_OFS (STAT_OFS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .burst_clk  (burst_clk),
   .burst_busy (burst_busy),
   .done_flag  (done_flag),
   .prog_cnt   (prog_cnt)
);

// File: tb/cfgclk_burst_tb.sv
module cfgclk_burst_tb;
   localparam int ADDR_W = 8;
   localparam int CNT_W  = 12;
   localparam int DIV    = 3;
   localparam logic [ADDR_W-1:0] A_CNT  = 8'h08;
   localparam logic [ADDR_W-1:0] A_STAT = 8'h0C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_rdata;
   logic              burst_clk;
   logic              burst_busy;

   int errs = 0;
   int checks = 0;
   int rise_cnt = 0;

   always #2 clk = ~clk;

   always @(posedge burst_clk) rise_cnt++;

   cfgclk_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV(DIV)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata),
      .burst_clk  (burst_clk),
      .burst_busy (burst_busy)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic clear_done();
      logic [31:0] v;
      wr(A_STAT, 32'h1);
      rd(A_STAT, v);
      chk("R5", "status after clear", v, 0);
   endtask

   task automatic run_burst(input logic [31:0] data, input int n, input string req);
      logic [31:0] v;
      int cyc = 0, rises = 0, hrun = 0, lrun = 0, badw = 0;
      logic prev = 1'b0;
      wr(A_CNT, data);
      if (n > 0) begin
         chk("R2", "busy after start", burst_busy, 1);
         chk("R2", "clk after start", burst_clk, 1);
         rd(A_STAT, v);
         chk("R8", "status busy bit mid burst", v, 2);
      end else begin
         chk("R6", "busy after zero count", burst_busy, 0);
      end
      while (burst_busy && cyc < 20000) begin
         if (burst_clk && !prev) begin
            if (rises > 0 && lrun != DIV) badw++;
            rises++; hrun = 1;
         end else if (burst_clk) begin
            hrun++;
         end else if (prev) begin
            if (hrun != DIV) badw++;
            lrun = 1;
         end else begin
            lrun++;
         end
         prev = burst_clk;
         cyc++;
         @(negedge clk);
      end
      if (n > 0 && lrun != DIV) badw++;
      chk(req, "busy cycles", cyc, 2 * DIV * n);
      chk(req, "pulse count", rises, n);
      chk("R3", "phase width errors", badw, 0);
      chk("R3", "clk low when idle", burst_clk, 0);
      rd(A_STAT, v);
      chk("R4", "done after burst", v, 1);
      rd(A_CNT, v);
      chk("R8", "count readback", v, n);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      chk("R10", "clk in reset", burst_clk, 0);
      chk("R10", "busy in reset", burst_busy, 0);
      rd(A_STAT, v);
      chk("R10", "status in reset", v, 0);
      rd(A_CNT, v);
      chk("R10", "count in reset", v, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      bus_addr = A_STAT; bus_rd = 1'b0;
      #1 chk("R1", "rdata with rd low", bus_rdata, 0);

      for (int n = 0; n <= 24; n++) begin
         clear_done();
         run_burst(32'(n), n, (n == 0) ? "R6" : "R3");
      end
      clear_done();
      run_burst(32'd256, 256, "R3");
      clear_done();
      run_burst(32'h7FF, 2047, "R3");
      clear_done();
      run_burst(32'hFFFF_F003, 3, "R2");

      wr(A_STAT, 32'hFFFF_FFFE);
      rd(A_STAT, v);
      chk("R5", "bit0 zero keeps done", v, 1);

      // R7: count write during burst is dropped
      clear_done();
      rise_cnt = 0;
      wr(A_CNT, 32'd5);
      wr(A_CNT, 32'd30);
      for (int i = 0; i < 1000 && burst_busy; i++) @(negedge clk);
      chk("R7", "pulses with mid-burst write", rise_cnt, 5);
      rd(A_CNT, v);
      chk("R7", "count readback unchanged", v, 5);

      // R5: clear landing on the final edge of a one-pulse burst
      clear_done();
      wr(A_CNT, 32'd1);
      repeat (2 * DIV - 1) @(negedge clk);
      bus_addr = A_STAT; bus_wdata = 32'h1; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R5", "busy at coincident clear", burst_busy, 0);
      rd(A_STAT, v);
      chk("R5", "set wins over clear", v, 1);

      // R9: unmapped and misaligned accesses
      wr(8'h00, 32'd7);
      wr(8'h10, 32'h1);
      wr(8'h0D, 32'h1);
      wr(8'h09, 32'd9);
      chk("R9", "busy after unmapped writes", burst_busy, 0);
      rd(A_STAT, v);
      chk("R9", "status after unmapped writes", v, 1);
      rd(A_CNT, v);
      chk("R9", "count after unmapped writes", v, 1);
      rd(8'h00, v);
      chk("R9", "read 0x00", v, 0);
      rd(8'h04, v);
      chk("R9", "read 0x04", v, 0);
      rd(8'h10, v);
      chk("R9", "read 0x10", v, 0);
      rd(8'h0D, v);
      chk("R9", "read 0x0D", v, 0);
      rd(A_CNT, v);
      chk("R1", "count offset 0x08 readable", v, 1);

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule